// File: doc/BRIEF.md
# I2C Address-Match Wake Detector

This block watches a two-wire serial bus while the chip is asleep. It looks for a start condition and clocks in the address byte that follows. When the 7-bit address in that byte equals the programmed slave address, it raises a wake interrupt and acknowledges the address by pulling SDA low. It does nothing beyond the address byte. Once the acknowledge slot ends it releases the bus, and the woken system takes over the data phase.

A bus-busy flag follows start and stop conditions whether the block is asleep or not. Firmware reads this flag before requesting sleep. A transaction that is already under way when sleep begins is not served: the block stays off the bus and answers with NACK, because the line floats high.

The SCL and SDA inputs are asynchronous. Each passes through a synchroniser, and every edge and bus condition is decoded from the synchronised samples.

Top module: `i2c_wake_detect`

## Requirements
- R1: After reset, `sda_pull_low`, `wake_irq`, `bus_busy` and `rw_bit` are all 0.
- R2: A start condition sets `bus_busy`. A start condition is SDA going 1→0 while SCL is 1, judged on the synchronised samples. A stop condition clears `bus_busy`. A stop condition is SDA going 0→1 while SCL is 1. The flag tracks the bus whatever the value of `sleep_en`.
- R3: A start condition begins address collection only while `sleep_en` is 1. With `sleep_en` at 0, `wake_irq` and `sda_pull_low` stay 0.
- R4: After a start, the block samples SDA on each of the next 8 SCL rising edges, most significant bit first. Bits 7:1 of the received byte form the address and bit 0 is the read/write flag.
- R5: When the address equals `own_addr`, `wake_irq` is high for exactly one clock cycle and `rw_bit` takes the received bit 0 (1 = read). `rw_bit` holds that value until the next match.
- R6: On a match, `sda_pull_low` rises on the SCL falling edge that follows the 8th bit. It stays high until the next SCL falling edge, which ends the acknowledge slot.
- R7: When the address differs from `own_addr`, there is no wake and no acknowledge, and the block waits for the next start.
- R8: If a transaction started while `sleep_en` was 0, the block neither acknowledges it nor wakes on it after `sleep_en` rises. This holds until a new start condition is seen.
- R9: A repeated start during address collection discards the partial byte and restarts the count at the first bit. A stop during address collection discards the partial byte and returns the block to idle.
- R10: When `sleep_en` falls, `sda_pull_low` goes to 0 within one clock and the block abandons the current transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level (asynchronous) |
| sda_in | input | 1 | Raw SDA line level (asynchronous) |
| own_addr | input | ADDR_W | Programmed 7-bit slave address |
| sleep_en | input | 1 | High while the system is in the low-power state |
| sda_pull_low | output | 1 | When high, the pad pulls SDA low (acknowledge) |
| wake_irq | output | 1 | One-cycle wake interrupt on an address match |
| bus_busy | output | 1 | High between a start and a stop condition |
| rw_bit | output | 1 | Read/write bit of the last matching address |

## Verification
The bench sends matching addresses with the write flag and with the read flag, and a near-miss address that differs in its lowest address bit. If the design took the address from the wrong bits, or compared only part of it, it would wake on the near miss or stay silent on the true match. A repeated start, and separately a stop, is placed in the middle of an address byte. A design that kept its bit count across either condition would assemble a shifted byte, and would then wake on garbage or miss the real address. Sleep is entered halfway through a byte that began while awake, and it is left during the acknowledge slot. A design that joined the transfer late would acknowledge a corrupt address, and one that ignored the exit would keep holding SDA low.

// File: rtl/i2c_wake_pkg.sv
package i2c_wake_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK_DRIVE
  } wake_st_e;
endpackage

// File: rtl/i2c_wake_sync.sv
module i2c_wake_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RESET_VAL}};
      last  <= RESET_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
  assign rise = dout & ~last;
  assign fall = ~dout & last;
endmodule

// File: rtl/i2c_wake_busmon.sv
module i2c_wake_busmon (
  input  logic clk,
  input  logic rst,
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_det,
  output logic stop_det,
  output logic busy
);
  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;

  always_ff @(posedge clk) begin
    if (rst)            busy <= 1'b0;
    else if (start_det) busy <= 1'b1;
    else if (stop_det)  busy <= 1'b0;
  end

  p_cond_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(start_det && stop_det));
endmodule

// File: rtl/i2c_wake_addr.sv
module i2c_wake_addr
  import i2c_wake_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_en,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              wake_irq,
  output logic              pull_low,
  output logic              rw_bit
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W);

  wake_st_e          st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] byte_nx;
  logic              last_bit;

  assign byte_nx  = {shreg[BYTE_W-2:0], sda_lvl};
  assign last_bit = (cnt == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      wake_irq <= 1'b0;
      pull_low <= 1'b0;
      rw_bit   <= 1'b0;
    end else begin
      wake_irq <= 1'b0;
      if (!sleep_en) begin
        st       <= ST_IDLE;
        pull_low <= 1'b0;
      end else if (start_det) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        pull_low <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        pull_low <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= byte_nx;
              if (last_bit) begin
                if (byte_nx[BYTE_W-1:1] == own_addr) begin
                  wake_irq <= 1'b1;
                  rw_bit   <= byte_nx[0];
                  st       <= ST_ACK_WAIT;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_ACK_WAIT: begin
            if (scl_fall) begin
              st       <= ST_ACK_DRIVE;
              pull_low <= 1'b1;
            end
          end
          ST_ACK_DRIVE: begin
            if (scl_fall) begin
              st       <= ST_IDLE;
              pull_low <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_wake_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    wake_irq |=> !wake_irq);
endmodule

// File: rtl/i2c_wake_detect.sv
module i2c_wake_detect #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sleep_en,
  output logic              sda_pull_low,
  output logic              wake_irq,
  output logic              bus_busy,
  output logic              rw_bit
);
  localparam int LINES = 2;
  localparam int L_SCL = 0;
  localparam int L_SDA = 1;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] rise;
  logic [LINES-1:0] fall;
  logic             start_det;
  logic             stop_det;

  assign raw[L_SCL] = scl_in;
  assign raw[L_SDA] = sda_in;

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    i2c_wake_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw[g]),
      .dout (lvl[g]),
      .rise (rise[g]),
      .fall (fall[g])
    );
  end

  i2c_wake_busmon u_busmon (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (lvl[L_SCL]),
    .sda_rise  (rise[L_SDA]),
    .sda_fall  (fall[L_SDA]),
    .start_det (start_det),
    .stop_det  (stop_det),
    .busy      (bus_busy)
  );

  i2c_wake_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .sleep_en  (sleep_en),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (rise[L_SCL]),
    .scl_fall  (fall[L_SCL]),
    .sda_lvl   (lvl[L_SDA]),
    .own_addr  (own_addr),
    .wake_irq  (wake_irq),
    .pull_low  (sda_pull_low),
    .rw_bit    (rw_bit)
  );

  p_ack_scl_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_low) |-> !lvl[L_SCL]);
  p_wake_in_txn_r5: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> bus_busy);
  p_pull_asleep_r10: assert property (@(posedge clk) disable iff (rst)
    sda_pull_low |-> $past(sleep_en));
  p_no_wake_awake_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(sleep_en) |-> !wake_irq);
endmodule

// File: tb/i2c_wake_detect_bench.sv
module i2c_wake_detect_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_drv = 1'b1;
  logic       sda_drv = 1'b1;
  logic       sleep = 1'b0;
  logic [6:0] own_addr = 7'h5A;
  logic       sda_pull_low, wake_irq, bus_busy, rw_bit;
  logic       scl_in, sda_in;

  assign scl_in = scl_drv;
  assign sda_in = sda_drv & ~sda_pull_low;

  always #10 clk = ~clk;

  i2c_wake_detect u_i2c_wake_detect (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .own_addr(own_addr), .sleep_en(sleep),
    .sda_pull_low(sda_pull_low), .wake_irq(wake_irq),
    .bus_busy(bus_busy), .rw_bit(rw_bit)
  );

  int checks = 0;
  int fails  = 0;
  int wakes  = 0;
  bit ack_seen = 0;

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int       m_st = 0;   // 0 idle, 1 collecting, 2 waiting ack slot, 3 driving ack
  int       m_cnt = 0;
  bit [7:0] m_sh = 0;
  bit       m_wake = 0, m_pull = 0, m_busy = 0, m_rw = 0;
  bit       qs[$];
  bit       qd[$];

  always @(posedge clk) begin
    bit cs, os, cd, od, st_c, sp_c, srise, sfall;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_sh = 0;
      m_wake = 0; m_pull = 0; m_busy = 0; m_rw = 0;
      qs = '{1'b1, 1'b1, 1'b1};
      qd = '{1'b1, 1'b1, 1'b1};
    end else begin
      qs.push_back(scl_in);
      qd.push_back(sda_in);
      cs = qs[1]; os = qs[0]; cd = qd[1]; od = qd[0];
      void'(qs.pop_front());
      void'(qd.pop_front());
      st_c  = od & ~cd & cs;
      sp_c  = ~od & cd & cs;
      srise = ~os & cs;
      sfall = os & ~cs;
      if (st_c) m_busy = 1;
      else if (sp_c) m_busy = 0;
      m_wake = 0;
      if (!sleep) begin
        m_st = 0; m_pull = 0;
      end else if (st_c) begin
        m_st = 1; m_cnt = 0; m_pull = 0;
      end else if (sp_c) begin
        m_st = 0; m_pull = 0;
      end else if (m_st == 1 && srise) begin
        m_sh = {m_sh[6:0], cd};
        if (m_cnt == 7) begin
          if (m_sh[7:1] == own_addr) begin
            m_wake = 1; m_rw = m_sh[0]; m_st = 2;
          end else m_st = 0;
        end else m_cnt++;
      end else if (m_st == 2 && sfall) begin
        m_st = 3; m_pull = 1;
      end else if (m_st == 3 && sfall) begin
        m_st = 0; m_pull = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 wake_irq", wake_irq, m_wake);
      chk("R6 sda_pull_low", sda_pull_low, m_pull);
      chk("R2 bus_busy", bus_busy, m_busy);
      chk("R5 rw_bit", rw_bit, m_rw);
      if (wake_irq === 1'b1) wakes++;
      if (sda_pull_low === 1'b1) ack_seen = 1;
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    sda_drv = 1; hold(4); scl_drv = 1; hold(8);
    sda_drv = 0; hold(8); scl_drv = 0; hold(4);
  endtask

  task automatic bit_c(bit b);
    sda_drv = b; hold(4); scl_drv = 1; hold(8); scl_drv = 0; hold(4);
  endtask

  task automatic stop_c();
    sda_drv = 0; hold(4); scl_drv = 1; hold(8); sda_drv = 1; hold(8);
  endtask

  task automatic txn(bit [7:0] b);
    start_c();
    for (int i = 7; i >= 0; i--) bit_c(b[i]);
    bit_c(1'b1);
    stop_c();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int w0;
    hold(3);
    rst = 0;
    hold(1);
    chk("R1 pull after reset", sda_pull_low, 1'b0);
    chk("R1 wake after reset", wake_irq, 1'b0);
    chk("R1 busy after reset", bus_busy, 1'b0);
    chk("R1 rw after reset", rw_bit, 1'b0);

    sleep = 1; hold(4);
    // R4 R5 R6: matching write address 0x5A -> byte 0xB4
    w0 = wakes; ack_seen = 0;
    txn(8'hB4);
    chk_int("R5 write match wake count", wakes - w0, 1);
    chk("R6 ack driven on match", ack_seen, 1'b1);
    chk("R5 rw after write", rw_bit, 1'b0);
    chk("R2 busy clear after stop", bus_busy, 1'b0);

    // R5: matching read
    w0 = wakes; ack_seen = 0;
    txn(8'hB5);
    chk_int("R5 read match wake count", wakes - w0, 1);
    chk("R5 rw after read", rw_bit, 1'b1);

    // R7: near miss 0x5B
    w0 = wakes; ack_seen = 0;
    txn(8'hB6);
    chk_int("R7 mismatch wake count", wakes - w0, 0);
    chk("R7 no ack on mismatch", ack_seen, 1'b0);

    // R3: awake, matching address ignored but busy tracked
    sleep = 0; w0 = wakes; ack_seen = 0;
    start_c();
    chk("R2 busy set while awake", bus_busy, 1'b1);
    for (int i = 7; i >= 0; i--) bit_c(w0 >= 0 ? 8'hB4 >> i : 1'b0);
    bit_c(1'b1);
    stop_c();
    chk_int("R3 no wake while awake", wakes - w0, 0);
    chk("R3 no ack while awake", ack_seen, 1'b0);

    // R8: sleep entered mid-byte
    w0 = wakes; ack_seen = 0;
    start_c();
    for (int i = 7; i >= 5; i--) bit_c(8'hB4 >> i);
    sleep = 1;
    for (int i = 4; i >= 0; i--) bit_c(8'hB4 >> i);
    bit_c(1'b1);
    stop_c();
    chk_int("R8 late sleep no wake", wakes - w0, 0);
    chk("R8 late sleep no ack", ack_seen, 1'b0);

    // R9: repeated start mid-address
    w0 = wakes; ack_seen = 0;
    start_c();
    for (int i = 7; i >= 4; i--) bit_c(8'h6C >> i);
    start_c();
    for (int i = 7; i >= 0; i--) bit_c(8'hB4 >> i);
    bit_c(1'b1);
    stop_c();
    chk_int("R9 restart then match wake", wakes - w0, 1);
    chk("R9 restart then ack", ack_seen, 1'b1);

    // R9: stop mid-address, then bits without start
    w0 = wakes; ack_seen = 0;
    start_c();
    for (int i = 7; i >= 4; i--) bit_c(8'hB4 >> i);
    stop_c();
    chk("R2 busy clear after abort stop", bus_busy, 1'b0);
    scl_drv = 0; hold(4);
    for (int i = 7; i >= 0; i--) bit_c(8'hB4 >> i);
    sda_drv = 1; hold(4); scl_drv = 1; hold(8);
    chk_int("R9 stop discards byte", wakes - w0, 0);
    chk("R9 stop no ack", ack_seen, 1'b0);

    // R10: sleep dropped in ack slot
    w0 = wakes;
    start_c();
    for (int i = 7; i >= 0; i--) bit_c(8'hB4 >> i);
    sda_drv = 1; hold(4);
    chk("R6 ack holding", sda_pull_low, 1'b1);
    sleep = 0; hold(2);
    chk("R10 ack released on wake", sda_pull_low, 1'b0);
    scl_drv = 1; hold(8); scl_drv = 0; hold(4);
    stop_c();
    chk_int("R10 single wake", wakes - w0, 1);

    hold(10);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule